// File: doc/BRIEF.md
# Gshare Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a shift register of recent branch directions across the whole program. That history is XORed with word-address bits of the branch PC to select one entry in a table of 2-bit saturating counters. The high bit of the selected counter is the prediction. Each prediction returns its table index and a snapshot of the history as it stood before the prediction. The caller carries both with the branch down the pipeline.

When the branch resolves, the caller sends back the returned index, the snapshot, the direction that was guessed and the real direction. The counter at that index is trained with the real direction. If the guess was wrong, the history is rebuilt from the snapshot with the real direction appended. Each prediction is shifted into the history speculatively. A request in the very next cycle therefore already sees the previous guess.

Top module: `gshare_predictor`

## Requirements
- R1: After reset, the history is all zeros and every counter holds 01 (weak not-taken). A first request therefore returns rsp_taken=0 and rsp_ckpt=0, and rsp_valid is 0 until a request is made.
- R2: The counter index is history[IDX_W-1:0] XOR req_pc_word, where req_pc_word is PC bits [IDX_W+1:2]. The index is returned on rsp_index.
- R3: rsp_valid is high in exactly the cycles that follow a cycle with req_valid high. rsp_index, rsp_ckpt and rsp_taken belong to that request.
- R4: Counter encoding is 00 strong not-taken, 01 weak not-taken, 10 weak taken and 11 strong taken. rsp_taken is bit 1 of the selected counter.
- R5: An update with upd_taken=1 increments the counter at upd_index, saturating at 11. With upd_taken=0 it decrements, saturating at 00.
- R6: A counter at 11 still predicts taken after one not-taken update and predicts not-taken after a second one. The reverse holds for a counter at 00.
- R7: Each prediction shifts its predicted direction into history bit 0, moving older bits left. A request in the next cycle uses the shifted history, and rsp_ckpt is the history before the request's own bit.
- R8: An update whose upd_taken differs from upd_guess sets the history to (upd_ckpt << 1) | upd_taken. This applies to a request in the same cycle, and it drops the bit of a prediction still in flight.
- R9: An update whose upd_taken equals upd_guess leaves the history unchanged.
- R10: An update changes only the counter at upd_index as supplied on the update port. All other counters keep their values.
- R11: When a request and an update select the same counter in the same cycle, the prediction uses the counter value from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Prediction request strobe |
| req_pc_word | input | IDX_W | Branch PC bits [IDX_W+1:2] |
| upd_valid | input | 1 | Resolved branch strobe |
| upd_index | input | IDX_W | Index returned at prediction time |
| upd_ckpt | input | HIST_W | History snapshot returned at prediction time |
| upd_taken | input | 1 | Actual branch direction |
| upd_guess | input | 1 | Direction that was predicted |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_taken | output | 1 | Predicted direction |
| rsp_index | output | IDX_W | Counter index used |
| rsp_ckpt | output | HIST_W | History before this prediction |

## Verification
The bench uses the default HIST_W=8 and IDX_W=8. Every history bit then enters the hash, and the table has 256 counters. The bench aims at any chosen counter by XORing the desired index with its own model of the current history. This lets it train, saturate and probe individual entries, and confirm that neighbouring entries stay untouched. With an 8-bit history, back-to-back requests, repairs during an in-flight prediction and same-cycle read/update collisions can all be seen directly on rsp_ckpt within a few cycles.

// File: rtl/gshare_pkg.sv
package gshare_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_NT = 2'b01;

  function automatic ctr_t ctr_next(input ctr_t cur, input logic taken);
    ctr_t res;
    if (taken) res = (cur == 2'b11) ? cur : cur + 2'b01;
    else       res = (cur == 2'b00) ? cur : cur - 2'b01;
    return res;
  endfunction

endpackage

// File: rtl/gshare_hash.sv
module gshare_hash #(
  parameter int HIST_W = 8,
  parameter int IDX_W  = 8
) (
  input  logic [HIST_W-1:0] hist,
  input  logic [IDX_W-1:0]  pc_word,
  output logic [IDX_W-1:0]  index
);

  logic [IDX_W-1:0] hist_fit;

  generate
    if (HIST_W >= IDX_W) begin : g_trunc
      assign hist_fit = hist[IDX_W-1:0];
    end else begin : g_extend
      assign hist_fit = {{(IDX_W-HIST_W){1'b0}}, hist};
    end
  endgenerate

  assign index = hist_fit ^ pc_word;

endmodule

// File: rtl/gshare_history.sv
module gshare_history #(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pend_valid,
  input  logic              pend_bit,
  input  logic              fix_valid,
  input  logic [HIST_W-1:0] fix_ckpt,
  input  logic              fix_bit,
  output logic [HIST_W-1:0] hist_now
);

  logic [HIST_W-1:0] ghr_q;

  always_comb begin
    if (fix_valid)
      hist_now = (fix_ckpt << 1) | HIST_W'(fix_bit);
    else if (pend_valid)
      hist_now = (ghr_q << 1) | HIST_W'(pend_bit);
    else
      hist_now = ghr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) ghr_q <= '0;
    else     ghr_q <= hist_now;
  end

endmodule

// File: rtl/gshare_pht.sv
module gshare_pht
  import gshare_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_dir,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  localparam int DEPTH = 1 << IDX_W;

  ctr_t tbl [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= CTR_WEAK_NT;
      rd_dir <= CTR_WEAK_NT[1];
    end else begin
      if (wr_en) tbl[wr_idx] <= ctr_next(tbl[wr_idx], wr_taken);
      if (rd_en) rd_dir <= tbl[rd_idx][1];
    end
  end

endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor #(
  parameter int HIST_W = 8,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  req_pc_word,
  input  logic              upd_valid,
  input  logic [IDX_W-1:0]  upd_index,
  input  logic [HIST_W-1:0] upd_ckpt,
  input  logic              upd_taken,
  input  logic              upd_guess,
  output logic              rsp_valid,
  output logic              rsp_taken,
  output logic [IDX_W-1:0]  rsp_index,
  output logic [HIST_W-1:0] rsp_ckpt
);

  logic              repair;
  logic [HIST_W-1:0] hist_now;
  logic [IDX_W-1:0]  idx_now;
  logic              dir_q;

  assign repair = upd_valid && (upd_taken != upd_guess);

  gshare_history #(.HIST_W(HIST_W)) u_hist (
    .clk        (clk),
    .rst        (rst),
    .pend_valid (rsp_valid),
    .pend_bit   (dir_q),
    .fix_valid  (repair),
    .fix_ckpt   (upd_ckpt),
    .fix_bit    (upd_taken),
    .hist_now   (hist_now)
  );

  gshare_hash #(.HIST_W(HIST_W), .IDX_W(IDX_W)) u_hash (
    .hist    (hist_now),
    .pc_word (req_pc_word),
    .index   (idx_now)
  );

  gshare_pht #(.IDX_W(IDX_W)) u_pht (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (req_valid),
    .rd_idx   (idx_now),
    .rd_dir   (dir_q),
    .wr_en    (upd_valid),
    .wr_idx   (upd_index),
    .wr_taken (upd_taken)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_index <= '0;
      rsp_ckpt  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_index <= idx_now;
        rsp_ckpt  <= hist_now;
      end
    end
  end

  assign rsp_taken = dir_q;

endmodule

// File: rtl/gshare_predictor_chk.sv
module gshare_predictor_chk #(
  parameter int HIST_W = 8,
  parameter int IDX_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [IDX_W-1:0]  req_pc_word,
  input logic              upd_valid,
  input logic [HIST_W-1:0] upd_ckpt,
  input logic              upd_taken,
  input logic              upd_guess,
  input logic              rsp_valid,
  input logic              rsp_taken,
  input logic [IDX_W-1:0]  rsp_index,
  input logic [HIST_W-1:0] rsp_ckpt
);

  logic bad_guess;
  assign bad_guess = upd_valid && (upd_taken != upd_guess);

  assert_rsp_follows_R3: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_rsp_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  assert_index_hash_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_index == (IDX_W'(rsp_ckpt) ^ $past(req_pc_word)));

  assert_spec_shift_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && rsp_valid && !bad_guess) |=>
      rsp_ckpt == (($past(rsp_ckpt) << 1) | HIST_W'($past(rsp_taken))));

  assert_repair_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && bad_guess) |=>
      rsp_ckpt == (($past(upd_ckpt) << 1) | HIST_W'($past(upd_taken))));

endmodule

bind gshare_predictor gshare_predictor_chk #(.HIST_W(HIST_W), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_pc_word (req_pc_word),
  .upd_valid   (upd_valid),
  .upd_ckpt    (upd_ckpt),
  .upd_taken   (upd_taken),
  .upd_guess   (upd_guess),
  .rsp_valid   (rsp_valid),
  .rsp_taken   (rsp_taken),
  .rsp_index   (rsp_index),
  .rsp_ckpt    (rsp_ckpt)
);

// File: tb/tb_gshare_predictor.sv
`timescale 1ns/1ps
module tb_gshare_predictor;

  localparam int HW = 8;
  localparam int IW = 8;
  localparam int NE = 1 << IW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [IW-1:0] req_pc_word = '0;
  logic          upd_valid = 1'b0;
  logic [IW-1:0] upd_index = '0;
  logic [HW-1:0] upd_ckpt = '0;
  logic          upd_taken = 1'b0;
  logic          upd_guess = 1'b0;
  logic          rsp_valid;
  logic          rsp_taken;
  logic [IW-1:0] rsp_index;
  logic [HW-1:0] rsp_ckpt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int            mctr [NE];
  logic [HW-1:0] mhist = '0;
  bit            mpend = 0;
  bit            mlast = 0;

  always #2.5 clk = ~clk;

  gshare_predictor #(.HIST_W(HW), .IDX_W(IW)) dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_pc_word(req_pc_word),
    .upd_valid(upd_valid), .upd_index(upd_index), .upd_ckpt(upd_ckpt),
    .upd_taken(upd_taken), .upd_guess(upd_guess),
    .rsp_valid(rsp_valid), .rsp_taken(rsp_taken),
    .rsp_index(rsp_index), .rsp_ckpt(rsp_ckpt)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // One clock: drive at negedge, model the edge, check at next negedge.
  // When aim is set, pcv is the counter index to hit.
  task automatic step(input bit rq, input bit aim, input logic [IW-1:0] pcv,
                      input bit up, input logic [IW-1:0] ui, input logic [HW-1:0] uc,
                      input bit ut, input bit ug, input string tag);
    logic [HW-1:0] eff;
    logic [IW-1:0] pc, eidx;
    bit            etk;
    if (up && (ut != ug)) eff = (uc << 1) | HW'(ut);
    else if (mpend)       eff = (mhist << 1) | HW'(mlast);
    else                  eff = mhist;
    pc   = aim ? (pcv ^ eff[IW-1:0]) : pcv;
    eidx = eff[IW-1:0] ^ pc;
    etk  = (mctr[eidx] >= 2);
    req_valid = rq; req_pc_word = pc;
    upd_valid = up; upd_index = ui; upd_ckpt = uc; upd_taken = ut; upd_guess = ug;
    mhist = eff;
    mpend = rq;
    if (rq) mlast = etk;
    if (up) mctr[ui] = ut ? ((mctr[ui] == 3) ? 3 : mctr[ui] + 1)
                          : ((mctr[ui] == 0) ? 0 : mctr[ui] - 1);
    @(negedge clk);
    check(tag, "rsp_valid", int'(rsp_valid), int'(rq));
    if (rq) begin
      check(tag, "rsp_index", int'(rsp_index), int'(eidx));
      check(tag, "rsp_ckpt",  int'(rsp_ckpt),  int'(eff));
      check(tag, "rsp_taken", int'(rsp_taken), int'(etk));
    end
  endtask

  task automatic idle();
    step(0, 0, '0, 0, '0, '0, 0, 0, "idle");
  endtask

  task automatic train(input logic [IW-1:0] idx, input bit tk, input string tag);
    step(0, 0, '0, 1, idx, '0, tk, tk, tag);
  endtask

  task automatic probe(input logic [IW-1:0] idx, input string tag);
    step(1, 1, idx, 0, '0, '0, 0, 0, tag);
  endtask

  task automatic t_reset();
    check("R1", "rsp_valid after reset", int'(rsp_valid), 0);
    check("R1", "rsp_taken after reset", int'(rsp_taken), 0);
    probe(8'h00, "R1");
    probe(8'h3C, "R1");
    probe(8'hFF, "R1");
    idle();
  endtask

  task automatic t_counters();
    train(8'd5, 1, "R5");
    train(8'd5, 1, "R5");
    train(8'd5, 1, "R5");
    probe(8'd5, "R4");
    idle();
    probe(8'd4, "R10");
    idle();
    train(8'd20, 0, "R5");
    train(8'd20, 0, "R5");
    train(8'd20, 0, "R5");
    train(8'd20, 1, "R5");
    probe(8'd20, "R5");
    idle();
    train(8'd20, 1, "R5");
    probe(8'd20, "R5");
    idle();
  endtask

  task automatic t_hyst();
    train(8'd40, 1, "R6");
    train(8'd40, 1, "R6");
    train(8'd40, 0, "R6");
    probe(8'd40, "R6");
    idle();
    train(8'd40, 0, "R6");
    probe(8'd40, "R6");
    idle();
  endtask

  task automatic t_hist();
    probe(8'd5, "R7");
    probe(8'd5, "R7");
    probe(8'd4, "R7");
    probe(8'd5, "R7");
    idle();
    probe(8'd4, "R7");
    idle();
  endtask

  task automatic t_repair();
    probe(8'd5, "R8");
    step(1, 1, 8'd4, 1, 8'd100, 8'hA5, 1, 0, "R8");
    check("R8", "repaired ckpt", int'(rsp_ckpt), 8'h4B);
    probe(8'd5, "R8");
    step(1, 1, 8'd5, 1, 8'd101, 8'h00, 1, 1, "R9");
    step(0, 0, '0, 1, 8'd102, 8'h33, 0, 0, "R9");
    probe(8'd4, "R9");
    idle();
    step(0, 0, '0, 1, 8'd103, 8'h0F, 0, 1, "R8");
    probe(8'd4, "R8");
    check("R8", "ckpt after idle repair", int'(rsp_ckpt), 8'h1E);
    idle();
  endtask

  task automatic t_collide();
    step(1, 1, 8'd60, 1, 8'd60, '0, 1, 1, "R11");
    check("R11", "old counter seen", int'(rsp_taken), 0);
    probe(8'd60, "R11");
    idle();
  endtask

  initial begin
    for (int i = 0; i < NE; i++) mctr[i] = 1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_counters();
    t_hyst();
    t_hist();
    t_repair();
    t_collide();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule